// File: doc/BRIEF.md
# DRAM Open-Row Read Controller

This block sits in front of an eight-bank DRAM array and serves single-line reads. A requester hands over a byte address through a valid/ready handshake. The block splits the address into bank, row and column, and looks up the row held open in that bank. It then picks one of three paths. On a row hit it issues the column read at once. On an idle bank it activates the row and then reads. On a row conflict it precharges the bank, activates the new row and then reads. Every gap between commands is a cycle count sampled from configuration pins while reset is held.

CAS latency cycles after the column read, the array returns eight 64-bit words of a 64-byte line. The block forwards each word with a valid strobe and the index of the word within the line. The first word is the one the request addressed (the critical word). Later words follow in ascending order and wrap modulo eight. The eighth word carries a last flag. The row is left open afterwards, so the next read to the same row is a hit.

The controller is a state machine. Its states are `S_IDLE`, `S_PRE`, `S_WAIT_RP`, `S_ACT`, `S_WAIT_RCD`, `S_RD`, `S_WAIT_CL` and `S_BURST`. Its transitions are:
- `S_IDLE` to `S_RD` on an accepted hit.
- `S_IDLE` to `S_ACT` on an accepted idle-bank request.
- `S_IDLE` to `S_PRE` on an accepted conflict.
- `S_PRE` to `S_WAIT_RP`, or straight to `S_ACT` when the precharge delay is 1.
- `S_WAIT_RP` to `S_ACT` when its timer expires.
- `S_ACT` to `S_WAIT_RCD`, or straight to `S_RD` when the activate delay is 1.
- `S_WAIT_RCD` to `S_RD` when its timer expires.
- `S_RD` to `S_WAIT_CL`, or straight to `S_BURST` when the CAS latency is 1.
- `S_WAIT_CL` to `S_BURST` when its timer expires.
- `S_BURST` to `S_IDLE` after the eighth beat.

Top module: `dram_rd_ctrl`

## Requirements
- R1: The request address splits as column = bits [12:0], bank = bits [15:13] and row = bits [29:16]. The critical word index is column bits [5:3]. The read command carries the column with bits [2:0] cleared, plus the bank and row of the request.
- R2: While reset is held and after it is released, `req_ready` is 1, `cmd_op` is NOP and `rd_valid` is 0. Every bank starts with no open row, so the first read to any bank takes the activate path.
- R3: On a hit (the bank's open row equals the requested row), the only command is RD (`cmd_op`=2). It is issued in the cycle after the request is accepted.
- R4: On an idle bank, ACT (`cmd_op`=1) is issued in the cycle after acceptance. RD follows tRCD cycles after ACT, with no PRE.
- R5: On a conflict (the bank has a different row open), PRE (`cmd_op`=3) is issued in the cycle after acceptance. ACT follows tRP cycles later, and RD follows tRCD cycles after ACT.
- R6: The first data beat is valid exactly CL cycles after the cycle in which RD is issued.
- R7: The open-row state of each bank is kept separately. Activating or precharging one bank leaves the open row of every other bank unchanged.
- R8: A read returns eight data beats in consecutive cycles. `rd_valid` is 1 on each beat and `rd_last` is 1 on the eighth beat only. `rd_word` on beat i equals (critical index + i) mod 8, and `rd_data` carries that word.
- R9: `req_ready` is 0 from the cycle after acceptance until the last beat has been delivered. A request presented while `req_ready` is 0 is ignored and issues no command.
- R10: After a burst the row stays open, so a following read to the same row is a hit.
- R11: CL, tRP and tRCD are sampled from the configuration pins while `rst_n` is low, with 0 treated as 1. Changing those pins after reset does not change any latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also loads the configuration |
| cfg_cas_lat | input | 4 | CAS latency in cycles, sampled during reset |
| cfg_t_rp | input | 4 | Precharge-to-activate delay, sampled during reset |
| cfg_t_rcd | input | 4 | Activate-to-read delay, sampled during reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 30 | Byte address of the request |
| req_ready | output | 1 | Controller can accept a request |
| cmd_op | output | 2 | Array command: 0 NOP, 1 ACT, 2 RD, 3 PRE |
| cmd_bank | output | 3 | Bank of the command |
| cmd_row | output | 14 | Row of the command |
| cmd_col | output | 13 | Column of the read, word aligned |
| dram_dq | input | 64 | Data returned by the array |
| rd_valid | output | 1 | Data beat valid |
| rd_last | output | 1 | Eighth beat of the burst |
| rd_word | output | 3 | Index within the line of the current beat |
| rd_data | output | 64 | Data of the current beat |

## Verification
A corrupted open-row entry changes the path chosen for the next read to that bank. That shows within one cycle of acceptance as a missing or extra PRE or ACT, or later as data from the wrong row. A timer or state error moves the RD command or the first beat off its expected cycle, and the bench checks each of those cycles exactly. A wrong beat counter shows on the very next beat as a broken wrap order or a misplaced last flag. Reading back rows across several banks, and reading again after each new reset, exposes bank cross-talk and stale state.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } dram_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_WAIT_RP,
        S_ACT,
        S_WAIT_RCD,
        S_RD,
        S_WAIT_CL,
        S_BURST
    } rd_state_e;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int BANK_W   = 3,
    parameter int ROW_W    = 14,
    parameter int COL_W    = 13,
    parameter int BEAT_W   = 3,
    parameter int BYTE_OFF = 3
) (
    input  logic [ROW_W+BANK_W+COL_W-1:0] addr,
    output logic [BANK_W-1:0]             bank,
    output logic [ROW_W-1:0]              row,
    output logic [COL_W-1:0]              col,
    output logic [BEAT_W-1:0]             crit
);
    localparam int BANK_LO = COL_W;
    localparam int ROW_LO  = COL_W + BANK_W;

    always_comb begin
        col  = addr[COL_W-1:0];
        bank = addr[BANK_LO +: BANK_W];
        row  = addr[ROW_LO +: ROW_W];
        crit = addr[BYTE_OFF +: BEAT_W];
    end
endmodule

// File: rtl/dram_row_table.sv
module dram_row_table #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_open,
    output logic              look_hit
);
    localparam int NBANKS = 1 << BANK_W;

    logic [NBANKS-1:0]       open_vec;
    logic [NBANKS*ROW_W-1:0] rows_flat;

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (open_en && (upd_bank == BANK_W'(g))) begin
                open_r <= 1'b1;
                row_r  <= upd_row;
            end else if (close_en && (upd_bank == BANK_W'(g))) begin
                open_r <= 1'b0;
            end
        end

        assign open_vec[g]                  = open_r;
        assign rows_flat[g*ROW_W +: ROW_W]  = row_r;
    end

    logic [ROW_W-1:0] cur_row;

    always_comb begin
        look_open = open_vec[look_bank];
        cur_row   = rows_flat[look_bank*ROW_W +: ROW_W];
        look_hit  = look_open && (cur_row == look_row);
    end
endmodule

// File: rtl/dram_beat_seq.sv
module dram_beat_seq #(
    parameter int BEATS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [$clog2(BEATS)-1:0] crit,
    input  logic                     run,
    output logic [$clog2(BEATS)-1:0] word,
    output logic                     last
);
    localparam int BEAT_W = $clog2(BEATS);

    logic [BEAT_W-1:0] crit_q;
    logic [BEAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            crit_q <= crit;
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        word = crit_q + cnt_q;
        last = run && (cnt_q == BEAT_W'(BEATS - 1));
    end
endmodule

// File: rtl/dram_rd_ctrl.sv
module dram_rd_ctrl
    import dram_rd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 13,
    parameter int DATA_W = 64,
    parameter int BEATS  = 8,
    parameter int TW     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TW-1:0]                 cfg_cas_lat,
    input  logic [TW-1:0]                 cfg_t_rp,
    input  logic [TW-1:0]                 cfg_t_rcd,
    input  logic                          req_valid,
    input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
    output logic                          req_ready,
    output logic [1:0]                    cmd_op,
    output logic [BANK_W-1:0]             cmd_bank,
    output logic [ROW_W-1:0]              cmd_row,
    output logic [COL_W-1:0]              cmd_col,
    input  logic [DATA_W-1:0]             dram_dq,
    output logic                          rd_valid,
    output logic                          rd_last,
    output logic [$clog2(BEATS)-1:0]      rd_word,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int BEAT_W   = $clog2(BEATS);
    localparam int BYTE_OFF = $clog2(DATA_W / 8);

    rd_state_e state_q, state_d;

    logic [TW-1:0]     cl_q, trp_q, trcd_q;
    logic [TW-1:0]     timer_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic [BEAT_W-1:0] in_crit;
    logic              tbl_open, tbl_hit;
    logic              accept;
    logic              seq_last;
    logic [BEAT_W-1:0] seq_word;

    dram_addr_split #(
        .BANK_W  (BANK_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .BEAT_W  (BEAT_W),
        .BYTE_OFF(BYTE_OFF)
    ) u_split (
        .addr(req_addr),
        .bank(in_bank),
        .row (in_row),
        .col (in_col),
        .crit(in_crit)
    );

    dram_row_table #(
        .BANK_W(BANK_W),
        .ROW_W (ROW_W)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (state_q == S_ACT),
        .close_en (state_q == S_PRE),
        .upd_bank (bank_q),
        .upd_row  (row_q),
        .look_bank(in_bank),
        .look_row (in_row),
        .look_open(tbl_open),
        .look_hit (tbl_hit)
    );

    dram_beat_seq #(
        .BEATS(BEATS)
    ) u_beats (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .crit (in_crit),
        .run  (state_q == S_BURST),
        .word (seq_word),
        .last (seq_last)
    );

    assign accept = (state_q == S_IDLE) && req_valid;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (tbl_hit)       state_d = S_RD;
                    else if (tbl_open) state_d = S_PRE;
                    else               state_d = S_ACT;
                end
            end
            S_PRE:      state_d = (trp_q == TW'(1))  ? S_ACT : S_WAIT_RP;
            S_WAIT_RP:  state_d = (timer_q == TW'(1)) ? S_ACT : S_WAIT_RP;
            S_ACT:      state_d = (trcd_q == TW'(1)) ? S_RD : S_WAIT_RCD;
            S_WAIT_RCD: state_d = (timer_q == TW'(1)) ? S_RD : S_WAIT_RCD;
            S_RD:       state_d = (cl_q == TW'(1))   ? S_BURST : S_WAIT_CL;
            S_WAIT_CL:  state_d = (timer_q == TW'(1)) ? S_BURST : S_WAIT_CL;
            S_BURST:    state_d = seq_last ? S_IDLE : S_BURST;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register, timer, request latch and reset-time configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            timer_q <= '0;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            cl_q    <= (cfg_cas_lat == '0) ? TW'(1) : cfg_cas_lat;
            trp_q   <= (cfg_t_rp    == '0) ? TW'(1) : cfg_t_rp;
            trcd_q  <= (cfg_t_rcd   == '0) ? TW'(1) : cfg_t_rcd;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bank_q <= in_bank;
                row_q  <= in_row;
                col_q  <= in_col;
            end
            unique case (state_q)
                S_PRE:                            timer_q <= trp_q - 1'b1;
                S_ACT:                            timer_q <= trcd_q - 1'b1;
                S_RD:                             timer_q <= cl_q - 1'b1;
                S_WAIT_RP, S_WAIT_RCD, S_WAIT_CL: timer_q <= timer_q - 1'b1;
                default:                          timer_q <= timer_q;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready = (state_q == S_IDLE);
        cmd_bank  = bank_q;
        cmd_row   = row_q;
        cmd_col   = {col_q[COL_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
        rd_valid  = (state_q == S_BURST);
        rd_last   = seq_last;
        rd_word   = seq_word;
        rd_data   = dram_dq;
        unique case (state_q)
            S_PRE:   cmd_op = CMD_PRE;
            S_ACT:   cmd_op = CMD_ACT;
            S_RD:    cmd_op = CMD_RD;
            default: cmd_op = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/dram_rd_ctrl_chk.sv
module dram_rd_ctrl_chk #(
    parameter int BANK_W = 3,
    parameter int BEAT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              rd_valid,
    input logic              rd_last,
    input logic [BEAT_W-1:0] rd_word
);
    // R9
    busy_during_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    // R9
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    cmd_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 2'd0) |-> !req_ready);

    // R8
    last_is_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R8
    beats_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> rd_valid);

    // R8
    word_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> (rd_word == BEAT_W'($past(rd_word) + 1'b1)));

    // R1
    bank_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(cmd_bank));
endmodule

bind dram_rd_ctrl dram_rd_ctrl_chk #(
    .BANK_W(BANK_W),
    .BEAT_W($clog2(BEATS))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .cmd_op   (cmd_op),
    .cmd_bank (cmd_bank),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .rd_word  (rd_word)
);

// File: tb/sim_dram_rd_ctrl.sv
`timescale 1ns/1ps
module sim_dram_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_cas_lat = 4'd3, cfg_t_rp = 4'd3, cfg_t_rcd = 4'd3;
    logic        req_valid = 1'b0;
    logic [29:0] req_addr = '0;
    logic        req_ready;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [12:0] cmd_col;
    logic [63:0] dram_dq;
    logic        rd_valid, rd_last;
    logic [2:0]  rd_word;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cur_cl = 3, cur_rp = 3, cur_rcd = 3;

    always #2.5 clk = ~clk;

    dram_rd_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_cas_lat(cfg_cas_lat), .cfg_t_rp(cfg_t_rp), .cfg_t_rcd(cfg_t_rcd),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .dram_dq(dram_dq), .rd_valid(rd_valid), .rd_last(rd_last),
        .rd_word(rd_word), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] dfun(input logic [2:0] b, input logic [13:0] r,
                                         input logic [6:0] line, input logic [2:0] w);
        return {37'h0, b, r, line, w};
    endfunction

    // ---------------- array model ----------------
    int          cyc = 0;
    int          m_start = -1000;
    logic [2:0]  m_bank;
    logic [13:0] m_rrow;
    logic [6:0]  m_line;
    logic [2:0]  m_crit;
    logic [7:0]  m_open = '0;
    logic [13:0] m_row [8];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_open <= '0;
        end else begin
            case (cmd_op)
                2'd1: begin
                    chk(!m_open[cmd_bank], "R5 ACT to bank with open row", 64'(m_open[cmd_bank]), 64'd0);
                    m_open[cmd_bank] <= 1'b1;
                    m_row[cmd_bank]  <= cmd_row;
                end
                2'd3: m_open[cmd_bank] <= 1'b0;
                2'd2: begin
                    chk(m_open[cmd_bank] && m_row[cmd_bank] == cmd_row, "R7 RD needs matching open row",
                        64'(m_open[cmd_bank]), 64'd1);
                    m_start <= cyc + cur_cl;
                    m_bank  <= cmd_bank;
                    m_rrow  <= m_row[cmd_bank];
                    m_line  <= cmd_col[12:6];
                    m_crit  <= cmd_col[5:3];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (cyc >= m_start && cyc < m_start + 8)
            dram_dq = dfun(m_bank, m_rrow, m_line, 3'(m_crit + 3'(cyc - m_start)));
        else
            dram_dq = '0;
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] mk(input int kind, input int row, input int bank,
                                       input int line, input int w);
        logic [29:0] a;
        a = {14'(row), 3'(bank), 7'(line), 3'(w), 3'd0};
        return {2'(kind), a};
    endfunction

    // kind: 0 hit, 1 idle bank, 2 conflict
    localparam logic [31:0] VEC [10] = '{
        mk(1, 5,     0, 10,  2),
        mk(0, 5,     0, 11,  7),
        mk(1, 9,     1, 3,   0),
        mk(0, 5,     0, 12,  4),
        mk(2, 6,     0, 0,   5),
        mk(0, 9,     1, 127, 3),
        mk(1, 16383, 7, 127, 7),
        mk(2, 0,     7, 0,   0),
        mk(0, 6,     0, 64,  1),
        mk(2, 2,     1, 1,   6)
    };

    task automatic apply_reset(input int cl, input int rp, input int rcd);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cas_lat = 4'(cl); cfg_t_rp = 4'(rp); cfg_t_rcd = 4'(rcd);
        cur_cl = cl; cur_rp = rp; cur_rcd = rcd;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R2 ready in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && cmd_op === 2'd0 && rd_valid === 1'b0, "R2 idle after reset",
            {req_ready, cmd_op, rd_valid}, 64'b1000);
    endtask

    task automatic do_read(input logic [29:0] a, input int kind, input bit hold, input string tag);
        int pre_at = -1, act_at = -1, rd_at = -1, first_beat = -1, ncmd = 0, nbeats = 0;
        int e_pre, e_act, e_rd, e_b0, e_ncmd;
        bit beats_ok = 1, ready_low = 1, last_ok = 1;
        logic [2:0] crit;
        crit = a[5:3];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        if (hold) req_addr = {a[29:16] + 14'd1, a[15:13] ^ 3'd1, a[12:0]};
        else      req_valid = 1'b0;
        for (int rel = 1; rel < 300; rel++) begin
            if (rel > 1) @(negedge clk);
            if (req_ready) ready_low = 0;
            if (cmd_op != 2'd0) ncmd++;
            if (cmd_op == 2'd3 && pre_at < 0) pre_at = rel;
            if (cmd_op == 2'd1 && act_at < 0) act_at = rel;
            if (cmd_op == 2'd2 && rd_at < 0)  rd_at = rel;
            if (rd_valid) begin
                if (first_beat < 0) first_beat = rel;
                if (rd_word !== 3'(crit + 3'(nbeats))) beats_ok = 0;
                if (rd_data !== dfun(a[15:13], a[29:16], a[12:6], 3'(crit + 3'(nbeats)))) beats_ok = 0;
                if (rd_last !== (nbeats == 7)) last_ok = 0;
                nbeats++;
            end
            if (rd_last || !rd_valid && nbeats > 0) begin
                req_valid = 1'b0;
                break;
            end
        end
        e_pre  = (kind == 2) ? 1 : -1;
        e_act  = (kind == 2) ? 1 + cur_rp : (kind == 1) ? 1 : -1;
        e_rd   = (kind == 2) ? 1 + cur_rp + cur_rcd : (kind == 1) ? 1 + cur_rcd : 1;
        e_b0   = e_rd + cur_cl;
        e_ncmd = kind + 1;
        if (kind == 0) chk(rd_at == e_rd && act_at < 0 && pre_at < 0, {"R3 R10 hit path ", tag}, 64'(rd_at), 64'(e_rd));
        if (kind == 1) chk(act_at == e_act && rd_at == e_rd && pre_at < 0, {"R4 idle path ", tag}, 64'(rd_at), 64'(e_rd));
        if (kind == 2) chk(pre_at == e_pre && act_at == e_act && rd_at == e_rd, {"R5 conflict path ", tag},
                           {32'(pre_at), 16'(act_at), 16'(rd_at)}, {32'(e_pre), 16'(e_act), 16'(e_rd)});
        chk(first_beat == e_b0, {"R6 first beat cycle ", tag}, 64'(first_beat), 64'(e_b0));
        chk(beats_ok && last_ok && nbeats == 8, {"R8 R1 burst order and data ", tag}, 64'(nbeats), 64'd8);
        chk(ready_low && ncmd == e_ncmd, {"R9 single request in flight ", tag}, 64'(ncmd), 64'(e_ncmd));
        @(negedge clk);
        chk(req_ready === 1'b1 && cmd_op === 2'd0, {"R9 ignored request issued nothing ", tag},
            {cmd_op, req_ready}, 64'b001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R2 R11: default configuration
        apply_reset(3, 3, 3);
        for (int i = 0; i < 10; i++)
            do_read(VEC[i][29:0], int'(VEC[i][31:30]), (i == 3), $sformatf("vec%0d", i));

        // R2 R7: after a new reset banks are idle again; skip-wait paths with all delays 1
        apply_reset(1, 1, 1);
        do_read({14'd6, 3'd0, 7'd4, 3'd3, 3'd0}, 1, 0, "r2_reidle");
        do_read({14'd7, 3'd2, 7'd4, 3'd3, 3'd0}, 1, 0, "d1_idle");
        do_read({14'd7, 3'd2, 7'd9, 3'd6, 3'd0}, 0, 1, "d1_hit");
        do_read({14'd8, 3'd2, 7'd9, 3'd0, 3'd0}, 2, 0, "d1_conflict");
        do_read({14'd6, 3'd0, 7'd1, 3'd1, 3'd0}, 0, 0, "r7_other_bank");

        // R11: sample 5/2/4, then move the pins; latencies must not follow
        apply_reset(5, 2, 4);
        cfg_cas_lat = 4'd9; cfg_t_rp = 4'd7; cfg_t_rcd = 4'd8;
        do_read({14'd100, 3'd3, 7'd2, 3'd7, 3'd0}, 1, 0, "r11_idle");
        do_read({14'd101, 3'd3, 7'd2, 3'd2, 3'd0}, 2, 0, "r11_conflict");
        do_read({14'd101, 3'd3, 7'd3, 3'd5, 3'd0}, 0, 0, "r11_hit");

        // R11: zero configuration treated as one
        apply_reset(0, 0, 0);
        cur_cl = 1; cur_rp = 1; cur_rcd = 1;
        do_read({14'd3, 3'd4, 7'd0, 3'd4, 3'd0}, 1, 0, "r11_zero_idle");
        do_read({14'd4, 3'd4, 7'd0, 3'd1, 3'd0}, 2, 0, "r11_zero_conflict");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule